// File: doc/BRIEF.md
# Instruction Length Front End

This unit sits just after instruction fetch. It takes a stream of 16-bit parcels and groups them into whole instructions. An instruction is one, two or three parcels long. The length is known from the first parcel alone, so the unit never needs the rest of the opcode to do its job.

For each instruction it presents four things: the instruction packed to the top of a 48-bit word, its parcel count, the parcel address of its first parcel, and the address of the next sequential instruction. Parcels arrive under a valid/ready handshake, and instructions leave under a second one. A redirect is a one-cycle flush pulse that carries a new start address. It drops whatever was half built and restarts the address count at that address.

Top module: `insn_len_front`

## Requirements
- R1: The length comes from bits [15:14] of an instruction's first parcel. Codes 00 and 01 mean one parcel, 10 means two and 11 means three. `out_len_o` reports that count as 1, 2 or 3.
- R2: `out_insn_o` holds the first parcel in [47:32], the second in [31:16] and the third in [15:0]. Any parcel slot past the length reads as zero.
- R3: An instruction is presented only after all of its parcels have been accepted. Instructions come out in arrival order, none is lost and none is repeated. Input is taken at up to one parcel per cycle, and output is at most one instruction per cycle.
- R4: `out_addr_o` is the parcel address of the instruction's first parcel. `out_next_addr_o` equals `out_addr_o` plus the parcel count, modulo 2^AW. Each following instruction starts at the previous one's next address.
- R5: `in_ready_o` is low exactly when `out_valid_o` is high and `out_ready_i` is low. While stalled, every output stays unchanged.
- R6: A cycle with `flush_i` high does three things. It discards any partial instruction and any pending output, so `out_valid_o` is low in the next cycle. It ignores the parcel offered in that cycle. It makes the next instruction start at `redirect_addr_i`.
- R7: After reset `out_valid_o` is low and `in_ready_o` is high. The first instruction starts at address RESET_ADDR, which defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: drop partial and pending work |
| redirect_addr_i | input | AW | Start parcel address used on flush |
| in_valid_i | input | 1 | Parcel offered |
| in_parcel_i | input | 16 | Parcel data |
| in_ready_o | output | 1 | Parcel taken when high together with valid |
| out_valid_o | output | 1 | Instruction available |
| out_ready_i | input | 1 | Consumer takes the instruction |
| out_insn_o | output | 48 | Instruction packed to the top, unused bits zero |
| out_len_o | output | 2 | Parcel count, 1 to 3 |
| out_addr_o | output | AW | Parcel address of the first parcel |
| out_next_addr_o | output | AW | Address of the next sequential instruction |

## Verification
A corrupted parcel counter or a wrongly latched length does not stay hidden. It splits or merges instructions, so at the very next output the packed word has non-zero tail bits or wrong parcel contents. From that point every following address is off as well. A broken address register shows up as a break in the chain between one instruction's next address and the following one's start address, within one instruction. A stall-handling fault shows up in the cycle it occurs, either as a changed output or as ready staying high. The bench compares every emitted instruction against values computed arithmetically. It covers long streams that mix all four length codes, random input gaps and output stalls, and flushes that land on a partial instruction, on a pending output and near address wrap.

// File: rtl/ilf_pkg.sv
package ilf_pkg;
  // parcel count from the 2-bit length code at the top of the first parcel
  function automatic logic [1:0] parcels_of(input logic [1:0] code);
    unique case (code)
      2'b10:   parcels_of = 2'd2;
      2'b11:   parcels_of = 2'd3;
      default: parcels_of = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/ilf_len_dec.sv
module ilf_len_dec (
  input  logic [1:0] code_i,
  output logic [1:0] nparc_o
);
  always_comb nparc_o = ilf_pkg::parcels_of(code_i);
endmodule

// File: rtl/ilf_asm.sv
module ilf_asm #(
  parameter int PW   = 16,
  parameter int MAXP = 3,
  localparam int CW  = $clog2(MAXP + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic [PW-1:0]      parcel_i,
  input  logic [CW-1:0]      nparc_i,
  output logic               done_o,
  output logic [MAXP*PW-1:0] insn_o,
  output logic [CW-1:0]      len_o
);
  logic [MAXP-2:0][PW-1:0] hold_q;
  logic [CW-1:0]           cnt_q, need_q, need;

  always_comb begin
    need   = (cnt_q == '0) ? nparc_i : need_q;
    done_o = push_i && (CW'(cnt_q + 1'b1) == need);
    len_o  = need;
  end

  // slot k: held parcel, current parcel, or zero past the length
  for (genvar k = 0; k < MAXP; k++) begin : g_slot
    if (k < MAXP - 1) begin : g_held
      assign insn_o[(MAXP-k)*PW-1 -: PW] =
        (CW'(k) < cnt_q)  ? hold_q[k] :
        (CW'(k) == cnt_q) ? parcel_i  : '0;
    end else begin : g_last
      assign insn_o[(MAXP-k)*PW-1 -: PW] = (CW'(k) == cnt_q) ? parcel_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      cnt_q  <= '0;
      need_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      if (done_o) begin
        cnt_q <= '0;
      end else begin
        for (int k = 0; k < MAXP - 1; k++)
          if (cnt_q == CW'(k)) hold_q[k] <= parcel_i;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) need_q <= nparc_i;
      end
    end
  end
endmodule

// File: rtl/ilf_out.sv
module ilf_out #(
  parameter int              W          = 48,
  parameter int              AW         = 16,
  parameter int              LW         = 2,
  parameter logic [AW-1:0]   RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          load_i,
  input  logic [W-1:0]  insn_i,
  input  logic [LW-1:0] len_i,
  input  logic          out_ready_i,
  output logic          valid_o,
  output logic [W-1:0]  insn_o,
  output logic [LW-1:0] len_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_nx;

  assign pc_nx = pc_q + AW'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      insn_o  <= '0;
      len_o   <= '0;
      addr_o  <= '0;
      next_o  <= '0;
      pc_q    <= RESET_ADDR;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      pc_q    <= redirect_addr_i;
    end else if (load_i) begin
      valid_o <= 1'b1;
      insn_o  <= insn_i;
      len_o   <= len_i;
      addr_o  <= pc_q;
      next_o  <= pc_nx;
      pc_q    <= pc_nx;
    end else if (out_ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/insn_len_front.sv
module insn_len_front #(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int           PW         = 16,
  localparam int           MAXP       = 3,
  localparam int           IW         = PW * MAXP,
  localparam int           CW         = $clog2(MAXP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          in_valid_i,
  input  logic [PW-1:0] in_parcel_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [IW-1:0] out_insn_o,
  output logic [CW-1:0] out_len_o,
  output logic [AW-1:0] out_addr_o,
  output logic [AW-1:0] out_next_addr_o
);
  logic          push, done;
  logic [CW-1:0] nparc, len;
  logic [IW-1:0] insn;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign push       = in_valid_i && in_ready_o && !flush_i;

  ilf_len_dec i_len_dec (
    .code_i  (in_parcel_i[PW-1 -: 2]),
    .nparc_o (nparc)
  );

  ilf_asm #(.PW(PW), .MAXP(MAXP)) i_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .push_i   (push),
    .parcel_i (in_parcel_i),
    .nparc_i  (nparc),
    .done_o   (done),
    .insn_o   (insn),
    .len_o    (len)
  );

  ilf_out #(.W(IW), .AW(AW), .LW(CW), .RESET_ADDR(RESET_ADDR)) i_out (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (flush_i),
    .redirect_addr_i (redirect_addr_i),
    .load_i          (done),
    .insn_i          (insn),
    .len_i           (len),
    .out_ready_i     (out_ready_i),
    .valid_o         (out_valid_o),
    .insn_o          (out_insn_o),
    .len_o           (out_len_o),
    .addr_o          (out_addr_o),
    .next_o          (out_next_addr_o)
  );
endmodule

// File: rtl/ilf_chk.sv
module ilf_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [47:0]   out_insn_o,
  input logic [1:0]    out_len_o,
  input logic [AW-1:0] out_addr_o,
  input logic [AW-1:0] out_next_addr_o
);
  logic          have_q;
  logic [AW-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      exp_q  <= '0;
    end else if (flush_i) begin
      have_q <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      have_q <= 1'b1;
      exp_q  <= out_next_addr_o;
    end
  end

  p_len_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_len_o == ilf_pkg::parcels_of(out_insn_o[47:46]));

  p_zero_tail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_len_o != 2'd3 |-> out_insn_o[15:0] == '0 &&
      (out_len_o != 2'd1 || out_insn_o[31:16] == '0));

  p_next_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_next_addr_o == out_addr_o + AW'(out_len_o));

  p_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q && out_valid_o |-> out_addr_o == exp_q);

  p_backpress_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !flush_i |=> out_valid_o &&
      $stable(out_insn_o) && $stable(out_addr_o) && $stable(out_len_o));

  p_flush_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);
endmodule

bind insn_len_front ilf_chk #(.AW(AW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .in_ready_o      (in_ready_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_insn_o      (out_insn_o),
  .out_len_o       (out_len_o),
  .out_addr_o      (out_addr_o),
  .out_next_addr_o (out_next_addr_o)
);

// File: tb/test_insn_len_front.sv
`timescale 1ns/1ps
module test_insn_len_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] redir = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_parcel = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] out_insn;
  logic [1:0]  out_len;
  logic [15:0] out_addr, out_next;

  int vec = 0;
  int miss = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [15:0] p_arr [0:2047];
  logic [47:0] e_insn [0:1023];
  logic [1:0]  e_len [0:1023];
  logic [15:0] e_addr [0:1023];
  logic [15:0] e_next [0:1023];

  always #2.5 clk = ~clk;

  insn_len_front i_insn_len_front (
    .clk_i (clk), .rst_ni (rst_n), .flush_i (flush), .redirect_addr_i (redir),
    .in_valid_i (in_valid), .in_parcel_i (in_parcel), .in_ready_o (in_ready),
    .out_valid_o (out_valid), .out_ready_i (out_ready), .out_insn_o (out_insn),
    .out_len_o (out_len), .out_addr_o (out_addr), .out_next_addr_o (out_next)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // build a program of n instructions starting at addr a; returns parcel count
  task automatic build(input int n, input logic [15:0] a, input int seed, output int np);
    np = 0;
    for (int i = 0; i < n; i++) begin
      logic [1:0]  code = 2'((i + i / 4 + seed) % 4);
      logic [1:0]  len  = code[1] ? (code[0] ? 2'd3 : 2'd2) : 2'd1;
      logic [15:0] p0   = {code, 14'(i * 37 + seed * 11)};
      logic [15:0] p1   = 16'(i * 1009 + 77 + seed);
      logic [15:0] p2   = 16'(i * 523 + 154 + seed * 3);
      p_arr[np] = p0; np++;
      if (len > 1) begin p_arr[np] = p1; np++; end
      if (len > 2) begin p_arr[np] = p2; np++; end
      e_insn[i] = {p0, (len > 1) ? p1 : 16'h0, (len > 2) ? p2 : 16'h0};
      e_len[i]  = len;
      e_addr[i] = a;
      a = a + 16'(len);
      e_next[i] = a;
    end
  endtask

  task automatic run(input int n, input logic [15:0] a, input int seed, input bit stall);
    int np, pi = 0, oi = 0, guard = 0;
    bit prev_stall = 0;
    logic [47:0] prev_insn = '0;
    build(n, a, seed, np);
    while (oi < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (pi < np) && (!stall || lfsr[0] || lfsr[1]);
      in_parcel = (pi < np) ? p_arr[pi] : 16'h0;
      out_ready = !stall || lfsr[2] || lfsr[3];
      #1;
      if (prev_stall)
        chk(out_valid && out_insn == prev_insn, "R5 stalled output held", out_insn, prev_insn);
      if (out_valid && !out_ready)
        chk(!in_ready, "R5 ready low while stalled", in_ready, 0);
      prev_stall = out_valid && !out_ready;
      prev_insn  = out_insn;
      if (out_valid && out_ready) begin
        chk(out_insn == e_insn[oi], $sformatf("R2 R3 insn #%0d", oi), out_insn, e_insn[oi]);
        chk(out_len == e_len[oi], $sformatf("R1 len #%0d", oi), out_len, e_len[oi]);
        chk(out_addr == e_addr[oi] && out_next == e_next[oi], $sformatf("R4 addr/next #%0d", oi),
            {out_addr, out_next}, {e_addr[oi], e_next[oi]});
        oi++;
      end
      if (in_valid && in_ready) pi++;
    end
    chk(oi == n, "R3 all instructions emitted", oi, n);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    #1;
    chk(!out_valid, "R7 valid low in reset", out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R7 idle after reset", {out_valid, in_ready}, 2'b01);

    // R7/R3: back-to-back stream from reset address 0, no stalls
    run(64, 16'h0000, 0, 1'b0);
    // R5: random gaps and stalls over all code orderings
    run(300, e_next[63], 1, 1'b1);

    // R6: flush on a partial three-parcel instruction, parcel offered during flush ignored
    @(negedge clk);
    in_valid = 1'b1; in_parcel = 16'hC123;
    @(negedge clk);
    flush = 1'b1; redir = 16'h0100; in_parcel = 16'hFFFF;
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    #1;
    chk(!out_valid, "R6 nothing pending after flush", out_valid, 0);
    run(8, 16'h0100, 2, 1'b0);

    // R5/R6: pending output dropped by flush, then restart near wrap
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_parcel = 16'h1234;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && !in_ready, "R5 stalled output blocks input", {out_valid, in_ready}, 2'b10);
    chk(out_insn == 48'h1234_0000_0000, "R2 one-parcel packing", out_insn, 48'h1234_0000_0000);
    @(negedge clk);
    flush = 1'b1; redir = 16'hFFFE;
    @(negedge clk);
    flush = 1'b0; out_ready = 1'b1;
    #1;
    chk(!out_valid, "R6 pending output dropped", out_valid, 0);
    run(12, 16'hFFFE, 3, 1'b1);
    chk(e_next[0] == 16'h0001, "R4 wrap expectation", e_next[0], 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule